// File: doc/BRIEF.md
# Transmit Scatter-Gather Descriptor Engine

This block follows a chain of transmit descriptors held in memory and turns the buffers they point at into packets on a 32-bit AXI4-Stream master. A packet can be split across several descriptors. A start-of-packet flag in a descriptor's control word opens the packet, and an end-of-packet flag closes it. The six application words carried by the opening descriptor are captured and held on an output bus for the downstream consumer. When a buffer has been sent, the engine writes the descriptor's status word back with the byte count and a done flag. It then moves to the next descriptor through the link pointer.

The engine reaches memory through a single 32-bit request port with a fixed read latency and has at most one access outstanding at a time. It starts a walk on a start pulse while the channel is running. The walk ends in one of two ways. Either the descriptor just finished is the tail pointer, or a fetched descriptor is already marked done. Either way the engine raises a one-cycle idle pulse. A separate one-cycle completion pulse marks every finished packet. Register storage and interrupt generation belong to the surrounding logic.

Top module: `tsg_tx_engine`

## Requirements
- R1: After reset, busy, m_tvalid, mem_req, done_pulse and idle_pulse are all low, and cur_ptr is zero.
- R2: A start pulse begins a walk only when run is high and the engine is not busy. Otherwise it is ignored: no memory request is made and busy stays low.
- R3: If the status word of a fetched descriptor (byte offset 28) has bit 31 set, the engine sends no data and writes nothing. It raises idle_pulse, and cur_ptr keeps that descriptor's address.
- R4: The buffer address is the low word at byte offset 8. Control bits 22:0 (byte offset 24) give the byte length. The buffer goes out as ceil(length/4) words read from consecutive word addresses. m_tkeep is 4'hF except on a final partial word, where its low (length mod 4) bits are set.
- R5: m_tlast is high only on the final word of a descriptor whose control bit 26 (end of packet) is set. A packet may span several descriptors.
- R6: When control bit 27 (start of packet) is set, the six words at byte offsets 32..52 appear on app_words, word i at bits 32*i+31:32*i. Descriptors without bit 27 leave app_words unchanged.
- R7: After a descriptor's buffer has been sent, the engine writes {1, 8'b0, length[22:0]} to its status word at byte offset 28.
- R8: done_pulse is high for exactly one cycle for each descriptor with the end-of-packet bit, during its status write-back.
- R9: After write-back, cur_ptr takes the low word of the link pointer at byte offset 0. If the descriptor just finished was at tail_ptr, the walk stops with a one-cycle idle_pulse.
- R10: While m_tvalid is high and m_tready is low, m_tdata, m_tkeep and m_tlast hold, and no later word is presented.
- R11: A head_load pulse while not busy sets cur_ptr to head_ptr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Channel running enable; gates start |
| start | input | 1 | Walk start pulse |
| head_load | input | 1 | Load head_ptr into the current pointer |
| head_ptr | input | ADDR_W | Address of the first descriptor |
| tail_ptr | input | ADDR_W | Address of the last descriptor to process |
| cur_ptr | output | ADDR_W | Current descriptor address |
| busy | output | 1 | Walk in progress |
| done_pulse | output | 1 | One-cycle packet completion |
| idle_pulse | output | 1 | One-cycle walk end |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid RD_LAT cycles after the request cycle |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream word accepted |
| m_tdata | output | 32 | Stream data, little-endian bytes |
| m_tkeep | output | 4 | Byte valid |
| m_tlast | output | 1 | Last word of packet |
| app_words | output | 32*APP_N | Application words of the current packet |

## Verification
The fault symptoms are fairly separable:
- A wrong step counter or field capture fetches the wrong word of the descriptor. This shows up within a few accesses as a wrong buffer address on mem_addr, or as wrong stream data on the next beat.
- A length or remaining-byte error shows as an extra or missing beat, or as a bad m_tkeep on the last word of that same descriptor.
- A bad pointer chase or tail compare shows at the end of the walk. Either idle_pulse never arrives (the bench watchdog catches this), or cur_ptr differs from the link value.
- Status write-back and application-word latching are checked by reading back memory and app_words after each walk.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_FREQ,
      S_FWAIT,
      S_BREQ,
      S_BWAIT,
      S_SEND,
      S_WB,
      S_ADV
   } tsg_state_t;

   // descriptor word indices (byte offset / 4)
   localparam int unsigned W_LINK   = 0;
   localparam int unsigned W_BUF    = 2;
   localparam int unsigned W_CTRL   = 6;
   localparam int unsigned W_STAT   = 7;
   localparam int unsigned W_APP0   = 8;

   localparam int unsigned LEN_W    = 23;
   localparam int unsigned BIT_EOP  = 26;
   localparam int unsigned BIT_SOP  = 27;
   localparam int unsigned BIT_DONE = 31;
endpackage

// File: rtl/tsg_rd_timer.sv
module tsg_rd_timer #(
   parameter int unsigned LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic ready
);
   generate
      if (LAT == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= issue;
         end
         assign ready = q;
      end else begin : g_chain
         logic [LAT-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[LAT-2:0], issue};
         end
         assign ready = sr[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/tsg_keep_gen.sv
module tsg_keep_gen #(
   parameter int unsigned BYTES = 4,
   parameter int unsigned LEN_W = 23
) (
   input  logic [LEN_W-1:0] rem,
   output logic [BYTES-1:0] keep,
   output logic             final_beat
);
   generate
      for (genvar i = 0; i < BYTES; i++) begin : g_lane
         assign keep[i] = (rem > LEN_W'(i));
      end
   endgenerate
   assign final_beat = (rem <= LEN_W'(BYTES));
endmodule

// File: rtl/tsg_app_bank.sv
module tsg_app_bank #(
   parameter int unsigned APP_N = 6,
   localparam int unsigned IW   = (APP_N > 1) ? $clog2(APP_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [31:0]       wr_data,
   output logic [32*APP_N-1:0] words
);
   generate
      for (genvar i = 0; i < APP_N; i++) begin : g_word
         logic [31:0] w;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           w <= '0;
            else if (wr_en && wr_idx == IW'(i))   w <= wr_data;
         end
         assign words[32*i +: 32] = w;
      end
   endgenerate
endmodule

// File: rtl/tsg_tx_engine.sv
module tsg_tx_engine
   import tsg_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned RD_LAT = 2,
   parameter int unsigned APP_N  = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  start,
   input  logic                  head_load,
   input  logic [ADDR_W-1:0]     head_ptr,
   input  logic [ADDR_W-1:0]     tail_ptr,
   output logic [ADDR_W-1:0]     cur_ptr,
   output logic                  busy,
   output logic                  done_pulse,
   output logic                  idle_pulse,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [31:0]           mem_wdata,
   input  logic [31:0]           mem_rdata,
   output logic                  m_tvalid,
   input  logic                  m_tready,
   output logic [31:0]           m_tdata,
   output logic [3:0]            m_tkeep,
   output logic                  m_tlast,
   output logic [32*APP_N-1:0]   app_words
);
   localparam int unsigned BYTES     = 4;
   localparam int unsigned LAST_STEP = 3 + APP_N;
   localparam int unsigned APP_IW    = (APP_N > 1) ? $clog2(APP_N) : 1;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
         $error("tsg_tx_engine: ADDR_W must be 8..32");
      end
      if (RD_LAT < 1 || RD_LAT > 8) begin : g_bad_lat
         $error("tsg_tx_engine: RD_LAT must be 1..8");
      end
      if (APP_N < 1 || APP_N > 8) begin : g_bad_app
         $error("tsg_tx_engine: APP_N must be 1..8");
      end
   endgenerate

   tsg_state_t        state_q;
   logic [3:0]        step_q;
   logic [ADDR_W-1:0] cur_q, link_q, bufa_q;
   logic [LEN_W-1:0]  len_q, rem_q;
   logic              eop_q, sop_q;
   logic [31:0]       data_q;
   logic              done_q, idle_q;

   logic              rd_ready, rd_issue;
   logic [4:0]        widx;
   logic [3:0]        keep;
   logic              final_beat;
   logic              app_we;
   logic [APP_IW-1:0] app_idx;

   // descriptor word order: status first so a finished descriptor costs one read
   always_comb begin
      unique case (step_q)
         4'd0:    widx = 5'(W_STAT);
         4'd1:    widx = 5'(W_CTRL);
         4'd2:    widx = 5'(W_LINK);
         4'd3:    widx = 5'(W_BUF);
         default: widx = 5'(W_APP0) + 5'(step_q - 4'd4);
      endcase
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_wdata = '0;
      unique case (state_q)
         S_FREQ: begin
            mem_req  = 1'b1;
            mem_addr = cur_q + {{(ADDR_W-7){1'b0}}, widx, 2'b00};
         end
         S_BREQ: begin
            mem_req  = (rem_q != '0);
            mem_addr = bufa_q;
         end
         S_WB: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur_q + ADDR_W'(4 * W_STAT);
            mem_wdata = {1'b1, {(31-LEN_W){1'b0}}, len_q};
         end
         default: ;
      endcase
   end

   assign rd_issue = mem_req && !mem_we;

   tsg_rd_timer #(.LAT(RD_LAT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (rd_issue),
      .ready (rd_ready)
   );

   tsg_keep_gen #(.BYTES(BYTES), .LEN_W(LEN_W)) u_keep (
      .rem        (rem_q),
      .keep       (keep),
      .final_beat (final_beat)
   );

   assign app_we  = (state_q == S_FWAIT) && rd_ready && (step_q >= 4'd4);
   assign app_idx = APP_IW'(step_q - 4'd4);

   tsg_app_bank #(.APP_N(APP_N)) u_app (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (app_we),
      .wr_idx  (app_idx),
      .wr_data (mem_rdata),
      .words   (app_words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         step_q  <= '0;
         cur_q   <= '0;
         link_q  <= '0;
         bufa_q  <= '0;
         len_q   <= '0;
         rem_q   <= '0;
         eop_q   <= 1'b0;
         sop_q   <= 1'b0;
         data_q  <= '0;
         done_q  <= 1'b0;
         idle_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         idle_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (head_load) cur_q <= head_ptr;
               if (start && run) begin
                  step_q  <= '0;
                  state_q <= S_FREQ;
               end
            end
            S_FREQ: state_q <= S_FWAIT;
            S_FWAIT: if (rd_ready) begin
               state_q <= S_FREQ;
               step_q  <= step_q + 4'd1;
               unique case (step_q)
                  4'd0: if (mem_rdata[BIT_DONE]) begin
                     state_q <= S_IDLE;
                     idle_q  <= 1'b1;
                  end
                  4'd1: begin
                     len_q <= mem_rdata[LEN_W-1:0];
                     rem_q <= mem_rdata[LEN_W-1:0];
                     eop_q <= mem_rdata[BIT_EOP];
                     sop_q <= mem_rdata[BIT_SOP];
                  end
                  4'd2: link_q <= mem_rdata[ADDR_W-1:0];
                  4'd3: begin
                     bufa_q <= mem_rdata[ADDR_W-1:0];
                     if (!sop_q) state_q <= S_BREQ;
                  end
                  default: if (step_q == 4'(LAST_STEP)) state_q <= S_BREQ;
               endcase
            end
            S_BREQ: state_q <= (rem_q == '0) ? S_WB : S_BWAIT;
            S_BWAIT: if (rd_ready) begin
               data_q  <= mem_rdata;
               state_q <= S_SEND;
            end
            S_SEND: if (m_tready) begin
               rem_q   <= final_beat ? '0 : rem_q - LEN_W'(BYTES);
               bufa_q  <= bufa_q + ADDR_W'(BYTES);
               state_q <= S_BREQ;
            end
            S_WB: begin
               done_q  <= eop_q;
               state_q <= S_ADV;
            end
            S_ADV: begin
               cur_q <= link_q;
               if (cur_q == tail_ptr) begin
                  idle_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  step_q  <= '0;
                  state_q <= S_FREQ;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign m_tvalid   = (state_q == S_SEND);
   assign m_tdata    = data_q;
   assign m_tkeep    = keep;
   assign m_tlast    = eop_q && final_beat;
   assign cur_ptr    = cur_q;
   assign busy       = (state_q != S_IDLE);
   assign done_pulse = done_q;
   assign idle_pulse = idle_q;
endmodule

// File: rtl/tsg_tx_engine_chk.sv
module tsg_tx_engine_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned APP_N  = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                head_load,
   input logic [ADDR_W-1:0]   head_ptr,
   input logic [ADDR_W-1:0]   cur_ptr,
   input logic                busy,
   input logic                done_pulse,
   input logic                idle_pulse,
   input logic                mem_req,
   input logic                mem_we,
   input logic [31:0]         mem_wdata,
   input logic                m_tvalid,
   input logic                m_tready,
   input logic [31:0]         m_tdata,
   input logic [3:0]          m_tkeep,
   input logic                m_tlast,
   input logic [32*APP_N-1:0] app_words
);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

   a_r4_keep_contig: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (m_tkeep != 4'h0) && (((m_tkeep + 4'h1) & m_tkeep) == 4'h0));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   a_r9_idle_ends: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> !busy);

   a_r7_wb_format: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[31] && (mem_wdata[30:23] == 8'h00));

   a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !m_tvalid);

   a_r11_head_load: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && head_load |=> cur_ptr == $past(head_ptr));

   a_r6_app_stable_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tready |=> $stable(app_words));
endmodule

bind tsg_tx_engine tsg_tx_engine_chk #(.ADDR_W(ADDR_W), .APP_N(APP_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .head_load(head_load), .head_ptr(head_ptr),
   .cur_ptr(cur_ptr), .busy(busy), .done_pulse(done_pulse), .idle_pulse(idle_pulse),
   .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
   .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
   .m_tkeep(m_tkeep), .m_tlast(m_tlast), .app_words(app_words)
);

// File: tb/tsg_tx_engine_bench.sv
`timescale 1ns/1ps
module tsg_tx_engine_bench;
   localparam int AW  = 32;
   localparam int LAT = 2;
   localparam int NA  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run = 1'b0, start = 1'b0, head_load = 1'b0;
   logic [AW-1:0] head_ptr = '0, tail_ptr = '0, cur_ptr;
   logic busy, done_pulse, idle_pulse;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic m_tvalid, m_tready, m_tlast;
   logic [31:0] m_tdata;
   logic [3:0] m_tkeep;
   logic [32*NA-1:0] app_words;

   always #2.5 clk = ~clk;

   tsg_tx_engine #(.ADDR_W(AW), .RD_LAT(LAT), .APP_N(NA)) u_tsg_tx_engine (.*);

   logic [31:0] mem [256];
   logic [31:0] pipe [LAT];
   always @(posedge clk) begin
      if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      pipe[0] <= mem[mem_addr[9:2]];
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
   end
   assign mem_rdata = pipe[LAT-1];

   int errors = 0, checks = 0;
   int nb = 0, ndone = 0, nidle = 0, nreq = 0, nwr = 0, cyc = 0;
   bit stall = 1'b0;
   logic [31:0] bd [16];
   logic [3:0]  bk [16];
   logic        bl [16];
   logic [32*NA-1:0] bapp [16];

   initial m_tready = 1'b1;
   always @(negedge clk) begin
      if (m_tvalid && m_tready && nb < 16) begin
         bd[nb] = m_tdata; bk[nb] = m_tkeep; bl[nb] = m_tlast; bapp[nb] = app_words;
         nb++;
      end
      if (done_pulse) ndone++;
      if (idle_pulse) nidle++;
      if (mem_req) nreq++;
      if (mem_req && mem_we) nwr++;
      cyc++;
      m_tready = stall ? ((cyc % 3) != 1) : 1'b1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put_desc(input int a, input int lnk, input int bufa, input int ctrl,
                           input int stat, input int appbase);
      mem[(a>>2)+0] = lnk;   mem[(a>>2)+1] = 0;
      mem[(a>>2)+2] = bufa;  mem[(a>>2)+3] = 0;
      mem[(a>>2)+6] = ctrl;  mem[(a>>2)+7] = stat;
      for (int i = 0; i < NA; i++) mem[(a>>2)+8+i] = appbase + i;
   endtask

   task automatic fill_buf(input int a, input int nwords, input int base);
      for (int k = 0; k < nwords; k++) mem[(a>>2)+k] = base + k;
   endtask

   function automatic logic [32*NA-1:0] app_exp(input int base);
      logic [32*NA-1:0] v;
      for (int i = 0; i < NA; i++) v[32*i +: 32] = base + i;
      return v;
   endfunction

   task automatic load_head(input int a);
      @(negedge clk); head_load = 1'b1; head_ptr = a;
      @(negedge clk); head_load = 1'b0;
   endtask

   task automatic walk;
      int n0;
      n0 = nidle;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int t = 0; t < 3000 && nidle == n0; t++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(!busy, "R1", "busy", busy, 0);
      chk(!m_tvalid, "R1", "tvalid", m_tvalid, 0);
      chk(!mem_req, "R1", "mem_req", mem_req, 0);
      chk(!done_pulse && !idle_pulse, "R1", "pulses", {done_pulse, idle_pulse}, 0);
      chk(cur_ptr == 0, "R1", "cur_ptr", cur_ptr, 0);
   endtask

   task automatic t_start_ignored;
      int r0;
      r0 = nreq;
      run = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (10) @(negedge clk);
      chk(!busy, "R2", "busy after start with run low", busy, 0);
      chk(nreq == r0, "R2", "requests with run low", nreq - r0, 0);
   endtask

   task automatic t_single;
      int b0, d0;
      put_desc(32'h000, 32'h040, 32'h200, (1<<27)|(1<<26)|10, 0, 32'h11110000);
      fill_buf(32'h200, 3, 32'hB0000000);
      b0 = nb; d0 = ndone;
      run = 1'b1; tail_ptr = 32'h000; stall = 1'b1;
      walk();
      stall = 1'b0;
      chk(nb - b0 == 3, "R4", "beat count len 10", nb - b0, 3);
      chk(bd[b0] == 32'hB0000000 && bd[b0+2] == 32'hB0000002, "R10", "data under stalls", bd[b0+2], 32'hB0000002);
      chk(bk[b0] == 4'hF && bk[b0+2] == 4'h3, "R4", "keep partial", bk[b0+2], 4'h3);
      chk(!bl[b0] && !bl[b0+1] && bl[b0+2], "R5", "tlast placement", {bl[b0], bl[b0+1], bl[b0+2]}, 3'b001);
      chk(bapp[b0] == app_exp(32'h11110000), "R6", "app words", bapp[b0][31:0], 32'h11110000);
      chk(mem[7] == 32'h8000000A, "R7", "status write-back", mem[7], 32'h8000000A);
      chk(ndone - d0 == 1, "R8", "done count", ndone - d0, 1);
      chk(cur_ptr == 32'h040, "R9", "cur_ptr after tail", cur_ptr, 32'h040);
   endtask

   task automatic t_multi;
      int b0, d0;
      load_head(32'h040);
      chk(cur_ptr == 32'h040, "R11", "head load", cur_ptr, 32'h040);
      put_desc(32'h040, 32'h080, 32'h280, (1<<27)|8, 0, 32'h22220000);
      put_desc(32'h080, 32'h100, 32'h300, (1<<26)|5, 0, 32'h33330000);
      fill_buf(32'h280, 2, 32'hC0000000);
      fill_buf(32'h300, 2, 32'hD0000000);
      b0 = nb; d0 = ndone;
      tail_ptr = 32'h080;
      walk();
      chk(nb - b0 == 4, "R5", "beats over two descriptors", nb - b0, 4);
      chk(!bl[b0+1] && bl[b0+3], "R5", "tlast only at packet end", {bl[b0+1], bl[b0+3]}, 2'b01);
      chk(bd[b0+2] == 32'hD0000000 && bk[b0+3] == 4'h1, "R4", "second buffer data/keep", bk[b0+3], 4'h1);
      chk(bapp[b0+3] == app_exp(32'h22220000), "R6", "app held past non-start desc", bapp[b0+3][31:0], 32'h22220000);
      chk(mem[(32'h040>>2)+7] == 32'h80000008 && mem[(32'h080>>2)+7] == 32'h80000005, "R7",
          "both statuses", mem[(32'h080>>2)+7], 32'h80000005);
      chk(ndone - d0 == 1, "R8", "one done per packet", ndone - d0, 1);
      chk(cur_ptr == 32'h100, "R9", "cur_ptr follows link", cur_ptr, 32'h100);
   endtask

   task automatic t_completed;
      int b0, w0, i0;
      load_head(32'h0C0);
      put_desc(32'h0C0, 32'h140, 32'h380, (1<<27)|(1<<26)|4, 32'h80000000, 32'h44440000);
      b0 = nb; w0 = nwr; i0 = nidle;
      tail_ptr = 32'h200;
      walk();
      chk(nb == b0, "R3", "no data from done desc", nb - b0, 0);
      chk(nwr == w0, "R3", "no write-back", nwr - w0, 0);
      chk(nidle - i0 == 1, "R3", "idle pulse", nidle - i0, 1);
      chk(cur_ptr == 32'h0C0, "R3", "cur_ptr kept", cur_ptr, 32'h0C0);
   endtask

   bit finished = 1'b0;
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_start_ignored();
      t_single();
      t_multi();
      t_completed();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule